// File: doc/BRIEF.md
# Checked Serial Write-Word Receiver

This block receives write words from a serial controller on a three-wire link: a serial clock, a data line and an active-low select. The select, the clock and the data are brought into the system clock domain through synchronizers. Data bits are shifted in on the rising edges of the serial clock, most significant bit first. When the select returns high, the frame is judged. A frame that is accepted puts its word on a parallel output together with a strobe that lasts one clock.

A mode input turns on integrity checking. When checking is off, a frame is 24 bits of data. When checking is on, the 24 data bits are followed by an 8-bit CRC, for 32 bits in all. The receiver computes the CRC itself while the data bits arrive. If the received CRC differs from the computed one, the word is dropped and an active-low fault output goes low. The controller therefore learns of corruption without reading anything back. The fault output stays low until the controller pulses a clear input, and the controller then resends the word.

Top module: `spi_pec_rx`

## Requirements
- R1: After reset, `err_n` is 1, `wr_stb` is 0 and `wr_data` is 0.
- R2: When checking is off (`pec_en`=0), a frame of exactly 24 clock rises delivers its bits on `wr_data`. The first bit received becomes bit 23.
- R3: When checking is on, a 32-bit frame whose last 8 bits equal the CRC of its first 24 bits delivers those first 24 bits on `wr_data`. The CRC uses polynomial 0x07 (x^8+x^2+x+1) and starts from 0x00. It is computed most significant bit first, in arrival order.
- R4: When checking is on, a 32-bit frame with a CRC that does not match gives no strobe, leaves `wr_data` unchanged and drives `err_n` to 0.
- R5: Once `err_n` is 0, it stays 0 until `err_clr` is sampled high. After that clock edge it returns to 1, unless R6 applies.
- R6: A failing frame that is judged in the same clock in which `err_clr` is sampled keeps `err_n` at 0.
- R7: When checking is off, a frame with a bit count other than 24 gives no strobe and leaves `err_n` unchanged.
- R8: When checking is on, a frame with a bit count other than 32 gives no strobe and drives `err_n` to 0.
- R9: `wr_stb` is high for exactly one clock per accepted frame. It is high in the third clock edge after `cs_n` rises, counting that edge as the third.
- R10: An accepted frame does not change `err_n`. A pending fault is left in place until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller; data is sampled on its rising edge |
| mosi | input | 1 | Serial data from the controller, most significant bit first |
| cs_n | input | 1 | Active-low frame select; its rising edge ends and judges the frame |
| pec_en | input | 1 | 1 selects 32-bit frames with a CRC check; 0 selects plain 24-bit frames |
| err_clr | input | 1 | Clear pulse for the fault output, in the system clock domain |
| wr_data | output | 24 | Last accepted data word |
| wr_stb | output | 1 | One-clock strobe marking a newly accepted word |
| err_n | output | 1 | Active-low fault output, held low until cleared |

## Verification
The bench builds the block with its default parameters: 24 data bits, an 8-bit CRC with polynomial 0x07 and two synchronizer stages. With two stages the delay from a select release to the strobe is a fixed three clocks, so a cycle-accurate reference model can predict every output on every clock. The 24-bit and 32-bit frame lengths exercise both modes. They also let the bench send frames one bit too short and one bit too long in each mode. A clear pulse can be placed in the exact clock in which a failing frame is judged.

// File: rtl/spi_pec_pkg.sv
// Package: shared types for the checked serial write receiver.
// Assumes: nothing beyond standard SystemVerilog.
package spi_pec_pkg;

    // Result of judging one frame at select release.
    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'd0,
        VERDICT_ACCEPT = 2'd1,
        VERDICT_REJECT = 2'd2
    } verdict_e;

endpackage

// File: rtl/spi_pec_sync.sv
// Module: multi-bit synchronizer, a separate flop chain for each bit.
// Assumes: each input is a level that holds for at least STAGES system
// clocks, so no pulse is lost; the bits may arrive skewed with respect
// to one another.
module spi_pec_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the asynchronous level through the chain of STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_pec_deframe.sv
// Module: shift register, bit counter and running serial CRC for one frame.
// Assumes: frame_start and bit_stb never arrive in the same clock.
// The CRC covers only the first DATA_W bits of the frame. The counter
// saturates, so an overlong frame can never wrap back to a legal length.
module spi_pec_deframe #(
    parameter int                DATA_W   = 24,
    parameter int                CRC_W    = 8,
    parameter logic [CRC_W-1:0]  CRC_POLY = 8'h07,
    localparam int               FRAME_W  = DATA_W + CRC_W,
    localparam int               CNT_W    = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               bit_stb,
    input  logic               bit_val,
    output logic [FRAME_W-1:0] shreg_o,
    output logic [CNT_W-1:0]   count_o,
    output logic [CRC_W-1:0]   crc_o
);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   count_q;
    logic [CRC_W-1:0]   crc_q;
    logic [CRC_W-1:0]   crc_next;
    logic               in_data;

    // One step of the serial CRC: feed back the top bit XORed with the input bit.
    always_comb begin
        crc_next = {crc_q[CRC_W-2:0], 1'b0}
                 ^ ((crc_q[CRC_W-1] ^ bit_val) ? CRC_POLY : '0);
        in_data  = (count_q < CNT_W'(DATA_W));
    end

    // Clear at the start of a frame, then shift, count and update the CRC on each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            count_q <= '0;
            crc_q   <= '0;
        end else if (frame_start) begin
            count_q <= '0;
            crc_q   <= '0;
        end else if (bit_stb) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], bit_val};
            if (count_q != '1) count_q <= count_q + 1'b1;
            if (in_data)       crc_q   <= crc_next;
        end
    end

    assign shreg_o = shreg_q;
    assign count_o = count_q;
    assign crc_o   = crc_q;

    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (count_o == '0)); // R7

endmodule

// File: rtl/spi_pec_judge.sv
// Module: judges the frame when the select is released.
// Assumes: the count, shift register and CRC are stable during the clock
// in which frame_end is high. pec_en is held steady for the whole frame.
module spi_pec_judge #(
    parameter int  DATA_W  = 24,
    parameter int  CRC_W   = 8,
    localparam int FRAME_W = DATA_W + CRC_W,
    localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic                       frame_end,
    input  logic                       pec_en,
    input  logic [FRAME_W-1:0]         shreg,
    input  logic [CNT_W-1:0]           count,
    input  logic [CRC_W-1:0]           crc_calc,
    output spi_pec_pkg::verdict_e      verdict,
    output logic [DATA_W-1:0]          data
);

    import spi_pec_pkg::*;

    // Pick the data word and the verdict from the mode, the count and the CRC match.
    always_comb begin
        verdict = VERDICT_NONE;
        data    = shreg[DATA_W-1:0];
        if (frame_end) begin
            if (!pec_en) begin
                if (count == CNT_W'(DATA_W)) verdict = VERDICT_ACCEPT;
            end else begin
                data = shreg[FRAME_W-1:CRC_W];
                if (count == CNT_W'(FRAME_W) && shreg[CRC_W-1:0] == crc_calc)
                    verdict = VERDICT_ACCEPT;
                else
                    verdict = VERDICT_REJECT;
            end
        end
    end

endmodule

// File: rtl/spi_pec_errflag.sv
// Module: sticky fault flag. A set in the same clock as a clear wins.
// Assumes: set_i and clr_i are single-clock pulses in the system clock domain.
module spi_pec_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the fault until a clear arrives; a set in the same clock overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R6
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R5

endmodule

// File: rtl/spi_pec_rx.sv
// Module: top of the checked serial write receiver.
// Assumes: the serial clock's high and low phases each last at least
// SYNC_STAGES+1 system clocks. mosi is stable around each rising serial
// clock edge. pec_en changes only while the select is high.
// The delay from a select rise to wr_stb is SYNC_STAGES+1 clocks.
module spi_pec_rx #(
    parameter int               DATA_W      = 24,
    parameter int               CRC_W       = 8,
    parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    input  logic              pec_en,
    input  logic              err_clr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              err_n
);

    import spi_pec_pkg::*;

    localparam int FRAME_W = DATA_W + CRC_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    logic [2:0]         sync_vec;
    logic               s_cs_n, s_sclk, s_mosi;
    logic               prev_cs_n, prev_sclk;
    logic               frame_start, frame_end, bit_stb;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   count;
    logic [CRC_W-1:0]   crc_calc;
    verdict_e           verdict;
    logic [DATA_W-1:0]  judged_data;
    logic               err_flag;
    logic [DATA_W-1:0]  wr_data_q;
    logic               wr_stb_q;

    spi_pec_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, mosi}),
        .sync_o  (sync_vec)
    );

    assign {s_cs_n, s_sclk, s_mosi} = sync_vec;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cs_n <= 1'b1;
            prev_sclk <= 1'b0;
        end else begin
            prev_cs_n <= s_cs_n;
            prev_sclk <= s_sclk;
        end
    end

    // Detect select edges, and rising serial clock edges inside a frame.
    always_comb begin
        frame_start = !s_cs_n &&  prev_cs_n;
        frame_end   =  s_cs_n && !prev_cs_n;
        bit_stb     =  s_sclk && !prev_sclk && !s_cs_n;
    end

    spi_pec_deframe #(
        .DATA_W   (DATA_W),
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY)
    ) u_deframe (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_stb     (bit_stb),
        .bit_val     (s_mosi),
        .shreg_o     (shreg),
        .count_o     (count),
        .crc_o       (crc_calc)
    );

    spi_pec_judge #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W)
    ) u_judge (
        .frame_end (frame_end),
        .pec_en    (pec_en),
        .shreg     (shreg),
        .count     (count),
        .crc_calc  (crc_calc),
        .verdict   (verdict),
        .data      (judged_data)
    );

    spi_pec_errflag u_errflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (verdict == VERDICT_REJECT),
        .clr_i  (err_clr),
        .flag_o (err_flag)
    );

    // Register an accepted word and raise its strobe for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data_q <= '0;
            wr_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= (verdict == VERDICT_ACCEPT);
            if (verdict == VERDICT_ACCEPT) wr_data_q <= judged_data;
        end
    end

    assign wr_data = wr_data_q;
    assign wr_stb  = wr_stb_q;
    assign err_n   = !err_flag;

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> $stable(wr_data)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && !err_clr) |=> !err_n); // R5
    AST_ACCEPT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && $fell(err_n))); // R10
    AST_PLAIN_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pec_en) |-> !$fell(err_n)); // R7

endmodule

// File: tb/spi_pec_rx_bench.sv
// Bench: drives serial frames and compares every output on every clock
// against a behavioural event model.
module spi_pec_rx_bench;

    localparam int DW = 24;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          mosi = 1'b0;
    logic          cs_n = 1'b1;
    logic          pec_en = 1'b0;
    logic          err_clr = 1'b0;
    logic [DW-1:0] wr_data;
    logic          wr_stb;
    logic          err_n;

    always #2 clk = ~clk;

    spi_pec_rx #(
        .DATA_W      (DW),
        .CRC_W       (CW),
        .CRC_POLY    (8'h07),
        .SYNC_STAGES (2)
    ) u_spi_pec_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .pec_en  (pec_en),
        .err_clr (err_clr),
        .wr_data (wr_data),
        .wr_stb  (wr_stb),
        .err_n   (err_n)
    );

    typedef struct {
        int            at;
        bit            stb;
        bit            set_err;
        bit            clr;
        logic [DW-1:0] data;
    } ev_t;

    int            checks = 0;
    int            errors = 0;
    int            cyc = 0;
    bit            run_cmp = 1'b0;
    string         cur_req = "R1";
    ev_t           evq[$];
    logic          exp_stb = 1'b0;
    logic          exp_err_n = 1'b1;
    logic [DW-1:0] exp_data = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] crc8_ref(logic [23:0] d);
        logic [7:0] c = 8'h00;
        for (int b = 2; b >= 0; b--) begin
            c = c ^ d[b*8 +: 8];
            for (int k = 0; k < 8; k++)
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // Model: apply the events due in this clock, then compare all outputs.
    always @(posedge clk) begin : model
        bit set_now;
        bit clr_now;
        cyc++;
        #1;
        if (run_cmp) begin
            set_now = 1'b0;
            clr_now = 1'b0;
            exp_stb = 1'b0;
            for (int i = evq.size() - 1; i >= 0; i--) begin
                if (evq[i].at == cyc) begin
                    if (evq[i].stb) begin
                        exp_stb  = 1'b1;
                        exp_data = evq[i].data;
                    end
                    if (evq[i].set_err) set_now = 1'b1;
                    if (evq[i].clr)     clr_now = 1'b1;
                    evq.delete(i);
                end
            end
            if (set_now)      exp_err_n = 1'b0;
            else if (clr_now) exp_err_n = 1'b1;
            chk(cur_req, "wr_stb",  {31'd0, wr_stb}, {31'd0, exp_stb});
            chk(cur_req, "err_n",   {31'd0, err_n},  {31'd0, exp_err_n});
            chk(cur_req, "wr_data", {8'd0, wr_data}, {8'd0, exp_data});
        end
    end

    task automatic push_ev(int at, bit stb, bit set_err, bit clr, logic [DW-1:0] data);
        ev_t e;
        e.at = at; e.stb = stb; e.set_err = set_err; e.clr = clr; e.data = data;
        evq.push_back(e);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        push_ev(cyc + 1, 1'b0, 1'b0, 1'b1, '0);
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // Send n bits of vec, MSB first, then predict the verdict. clr_gap > 0
    // pulses the clear that many clocks after the select is released.
    task automatic send(logic [39:0] vec, int n, int clr_gap);
        logic [DW-1:0] d;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = vec[39-i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        d = vec[39:16];
        if (!pec_en) begin
            if (n == 24) push_ev(cyc + 3, 1'b1, 1'b0, 1'b0, d);
        end else if (n == 32 && vec[15:8] == crc8_ref(d)) begin
            push_ev(cyc + 3, 1'b1, 1'b0, 1'b0, d);
        end else begin
            push_ev(cyc + 3, 1'b0, 1'b1, 1'b0, '0);
        end
        if (clr_gap > 0) begin
            repeat (clr_gap) @(negedge clk);
            err_clr = 1'b1;
            push_ev(cyc + 1, 1'b0, 1'b0, 1'b1, '0);
            @(negedge clk);
            err_clr = 1'b0;
        end
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [39:0] good(logic [23:0] d);
        return {d, crc8_ref(d), 8'h00};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset err_n",   {31'd0, err_n},  32'd1);
        chk("R1", "reset wr_stb",  {31'd0, wr_stb}, 32'd0);
        chk("R1", "reset wr_data", {8'd0, wr_data}, 32'd0);
        run_cmp = 1'b1;

        cur_req = "R2"; pec_en = 1'b0;
        send({24'hA5C3F0, 16'h0}, 24, 0);
        send({24'h000001, 16'h0}, 24, 0);
        send({24'hFFFFFF, 16'h0}, 24, 0);

        cur_req = "R7";
        send({24'h123456, 16'h0}, 23, 0);
        send({24'h654321, 16'hFFFF}, 25, 0);

        cur_req = "R3"; pec_en = 1'b1;
        send(good(24'h123456), 32, 0);
        send(good(24'h800000), 32, 0);

        cur_req = "R4";
        send(good(24'hDEADBE) ^ 40'h0000000100, 32, 0);
        cur_req = "R5";
        repeat (20) @(negedge clk);
        pulse_clr();
        repeat (6) @(negedge clk);

        cur_req = "R8";
        send(good(24'h0F0F0F), 31, 0);
        send(good(24'h0F0F0F), 33, 0);
        cur_req = "R10";
        send(good(24'h55AA55), 32, 0);
        cur_req = "R5";
        pulse_clr();
        repeat (6) @(negedge clk);

        cur_req = "R4";
        send(good(24'h112233) ^ 40'h0100000000, 32, 0);
        cur_req = "R6";
        pulse_clr();
        send(good(24'h445566) ^ 40'h0000000800, 32, 2);
        cur_req = "R5";
        pulse_clr();
        repeat (6) @(negedge clk);

        cur_req = "R9";
        send(good(24'h7E7E7E), 32, 0);
        pec_en = 1'b0;
        send({24'h3C3C3C, 16'h0}, 24, 0);

        repeat (10) @(negedge clk);
        chk("R9", "event queue drained", evq.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule